// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 28-bit physical address by reading two entries from an in-memory page table. Pages are 4 KB. The top ten bits of the virtual address select an entry in the level-1 table. The base of that table comes from the current process's base register, which reaches the block on the `root_base` input and is sampled when a request is accepted. A valid level-1 entry gives the frame that holds a level-2 table. The next ten bits select the level-2 entry, and that entry gives the physical frame. The low twelve bits of the address pass through unchanged.

The same pass that translates the address also checks the permissions of the final entry. A user-mode access to a supervisor page is refused. So is an access whose type is not allowed by the entry. Either case is reported as a protection violation. An invalid entry at either level ends the walk with a page-fault code. Only one walk runs at a time. The block issues one-cycle word-read requests and accepts a response after any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: For a walk that succeeds, `res_paddr[27:12]` is the 16-bit frame number in bits 31:16 of the level-2 entry, and `res_paddr[11:0]` equals `req_vaddr[11:0]`. In this case `res_fault` is 2'b00.
- R2: The first read goes to `root_base + req_vaddr[31:22]*4`. The base is the value sampled when the request was accepted.
- R3: The second read goes to `(level-1 entry bits 31:16) << 12` plus `req_vaddr[21:12]*4`.
- R4: If bit 0 (valid) of the level-1 entry is 0, the result has `res_fault` = 2'b01 and `res_paddr` = 0, and no second read is issued.
- R5: If bit 0 of the level-2 entry is 0, the result has `res_fault` = 2'b10 and `res_paddr` = 0.
- R6: If `req_user` is 1 and bit 1 (SUP) of the valid level-2 entry is 1, the result has `res_fault` = 2'b11 and `res_paddr` = 0.
- R7: `req_kind` is encoded 2'b00 read, 2'b01 write and 2'b10 execute. These kinds require entry bit 2 (READ), bit 3 (WRITE) and bit 4 (EXEC) respectively. If the required bit is clear, the result is `res_fault` = 2'b11 with `res_paddr` = 0. Kind 2'b11 always gives 2'b11.
- R8: A supervisor access (`req_user` = 0) to a SUP page whose type bit is set translates normally, as in R1.
- R9: `req_ready` is 0 from the cycle after acceptance until the cycle after the result handshake. Requests offered during that time have no effect on the result. `res_valid`, `res_paddr` and `res_fault` hold steady while `res_ready` is 0.
- R10: Each read request is a one-cycle pulse. It is issued in the cycle after acceptance, or in the cycle after the level-1 response. The result becomes valid in the cycle after the final response that decides it. No result appears before that entry has been read.
- R11: A synchronous active-high `rst` returns the block to idle in the next cycle. Idle means `req_ready` = 1, `mem_req_valid` = 0 and `res_valid` = 0, even if a walk was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access type: 00 read, 01 write, 10 execute |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| root_base | input | 28 | Physical base of the current level-1 table |
| mem_req_valid | output | 1 | One-cycle word-read request |
| mem_req_addr | output | 28 | Byte address of the entry to read |
| mem_resp_valid | input | 1 | Read data is present |
| mem_resp_data | input | 32 | Entry that was read |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer accepts |
| res_paddr | output | 28 | Physical address, 0 on a fault |
| res_fault | output | 2 | 00 none, 01 level-1 invalid, 10 level-2 invalid, 11 protection |

## Verification
A request accepted at one edge puts the level-1 read on the port one cycle later. The level-2 read follows one cycle after the level-1 response. The result becomes valid one cycle after the response that decides it and then stays until the handshake. The bench's behavioural model moves its stage on each rising edge from the inputs it drove, and it compares every output on each falling edge. Because the memory responder waits between one and five cycles, each stage is checked under several different delays. Each walk's final value is also checked at its handshake against a walk computed from the bench's own memory image.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 28,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_resp_valid,
  input  logic [PTE_W-1:0] mem_resp_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [PA_W-1:0]  res_paddr,
  output logic [1:0]       res_fault
);
  localparam int PFN_W = PA_W - OFF_W;
  localparam logic [1:0] F_NONE = 2'b00, F_L1 = 2'b01, F_L2 = 2'b10, F_PROT = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_REQ1, S_WAIT1, S_REQ2, S_WAIT2, S_DONE} st_t;
  st_t st;

  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q;
  logic             user_q;
  logic [PA_W-1:0]  base_q;
  logic [PFN_W-1:0] tbl_q;

  wire [IDX_W-1:0] idx1 = va_q[VA_W-1 -: IDX_W];
  wire [IDX_W-1:0] idx2 = va_q[OFF_W +: IDX_W];
  wire [PFN_W-1:0] pfn  = mem_resp_data[PTE_W-1 -: PFN_W];
  wire e_valid = mem_resp_data[0];
  wire e_sup   = mem_resp_data[1];

  logic type_ok;
  always_comb begin
    case (kind_q)
      2'b00:   type_ok = mem_resp_data[2];
      2'b01:   type_ok = mem_resp_data[3];
      2'b10:   type_ok = mem_resp_data[4];
      default: type_ok = 1'b0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = &{1'b0, mem_resp_data[PTE_W-PFN_W-1:5]};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ1) || (st == S_REQ2);
  assign mem_req_addr  = (st == S_REQ2)
                       ? ({tbl_q, {OFF_W{1'b0}}} + PA_W'({idx2, 2'b00}))
                       : (base_q + PA_W'({idx1, 2'b00}));
  assign res_valid     = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      va_q      <= '0;
      kind_q    <= '0;
      user_q    <= 1'b0;
      base_q    <= '0;
      tbl_q     <= '0;
      res_paddr <= '0;
      res_fault <= F_NONE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          kind_q <= req_kind;
          user_q <= req_user;
          base_q <= root_base;
          st     <= S_REQ1;
        end
        S_REQ1: st <= S_WAIT1;
        S_WAIT1: if (mem_resp_valid) begin
          if (!e_valid) begin
            res_fault <= F_L1;
            res_paddr <= '0;
            st        <= S_DONE;
          end else begin
            tbl_q <= pfn;
            st    <= S_REQ2;
          end
        end
        S_REQ2: st <= S_WAIT2;
        S_WAIT2: if (mem_resp_valid) begin
          st <= S_DONE;
          if (!e_valid) begin
            res_fault <= F_L2;
            res_paddr <= '0;
          end else if ((user_q && e_sup) || !type_ok) begin
            res_fault <= F_PROT;
            res_paddr <= '0;
          end else begin
            res_fault <= F_NONE;
            res_paddr <= {pfn, va_q[OFF_W-1:0]};
          end
        end
        S_DONE: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 28,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            mem_req_valid,
  input logic            res_valid,
  input logic            res_ready,
  input logic [PA_W-1:0] res_paddr,
  input logic [1:0]      res_fault
);
  logic [OFF_W-1:0] off_seen;
  always_ff @(posedge clk) begin
    if (rst) off_seen <= '0;
    else if (req_valid && req_ready) off_seen <= req_vaddr[OFF_W-1:0];
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst) mem_req_valid |=> !mem_req_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) req_ready |-> (!mem_req_valid && !res_valid)); // R10
  AST_BUSY_RESULT: assert property (@(posedge clk) disable iff (rst) res_valid |-> !req_ready); // R9
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) && $stable(res_fault))); // R9
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst) (res_valid && res_fault != 2'b00) |-> (res_paddr == '0)); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault == 2'b00) |-> (res_paddr[OFF_W-1:0] == off_seen)); // R1
  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (req_ready && !mem_req_valid && !res_valid)); // R11
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .mem_req_valid(mem_req_valid), .res_valid(res_valid), .res_ready(res_ready),
  .res_paddr(res_paddr), .res_fault(res_fault)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, req_valid, req_ready, req_user, mem_req_valid, mem_resp_valid, res_valid, res_ready;
  logic [31:0] req_vaddr, mem_resp_data;
  logic [1:0]  req_kind, res_fault;
  logic [27:0] root_base, mem_req_addr, res_paddr;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr), .res_fault(res_fault)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  logic [31:0] mem [int];

  function automatic logic [31:0] rd(logic [27:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void ref_walk(logic [31:0] va, logic [1:0] k, logic u, logic [27:0] b,
                                   output logic [1:0] f, output logic [27:0] pa);
    logic [31:0] e1, e2;
    logic need;
    e1 = rd(b + 28'(va[31:22]) * 4);
    f = 2'b00; pa = 28'h0;
    if (!e1[0]) begin f = 2'b01; return; end
    e2 = rd(28'(e1[31:16]) * 4096 + 28'(va[21:12]) * 4);
    if (!e2[0]) begin f = 2'b10; return; end
    need = (k == 2'd0) ? e2[2] : (k == 2'd1) ? e2[3] : (k == 2'd2) ? e2[4] : 1'b0;
    if ((u && e2[1]) || !need) begin f = 2'b11; return; end
    pa = {e2[31:16], va[11:0]};
  endfunction

  // behavioural stage model, stepped from driven inputs
  int          m_st = 0;
  logic [31:0] m_va;
  logic [1:0]  m_kind, m_f;
  logic        m_user;
  logic [27:0] m_base, m_a2, m_pa;
  always @(posedge clk) begin
    if (rst) m_st <= 0;
    else case (m_st)
      0: if (req_valid) begin
           m_va <= req_vaddr; m_kind <= req_kind; m_user <= req_user; m_base <= root_base; m_st <= 1;
         end
      1: m_st <= 2;
      2: if (mem_resp_valid) begin
           if (!mem_resp_data[0]) begin m_f <= 2'b01; m_pa <= 0; m_st <= 5; end
           else begin m_a2 <= 28'(mem_resp_data[31:16]) * 4096 + 28'(m_va[21:12]) * 4; m_st <= 3; end
         end
      3: m_st <= 4;
      4: if (mem_resp_valid) begin
           m_st <= 5;
           if (!mem_resp_data[0]) begin m_f <= 2'b10; m_pa <= 0; end
           else if ((m_user && mem_resp_data[1]) ||
                    !((m_kind == 0 && mem_resp_data[2]) || (m_kind == 1 && mem_resp_data[3]) ||
                      (m_kind == 2 && mem_resp_data[4]))) begin m_f <= 2'b11; m_pa <= 0; end
           else begin m_f <= 2'b00; m_pa <= {mem_resp_data[31:16], m_va[11:0]}; end
         end
      5: if (res_ready) m_st <= 0;
      default: m_st <= 0;
    endcase
  end

  bit live = 0;
  always @(negedge clk) begin
    cyc++;
    if (live && !rst) begin
      chk("R9 req_ready", 32'(req_ready), 32'(m_st == 0));
      chk("R10 mem_req_valid", 32'(mem_req_valid), 32'(m_st == 1 || m_st == 3));
      if (m_st == 1) chk("R2 level-1 address", 32'(mem_req_addr), 32'(m_base + 28'(m_va[31:22]) * 4));
      if (m_st == 3) chk("R3 level-2 address", 32'(mem_req_addr), 32'(m_a2));
      chk("R10 res_valid", 32'(res_valid), 32'(m_st == 5));
      if (m_st == 5) begin
        chk("R4 R5 R6 R7 res_fault", 32'(res_fault), 32'(m_f));
        chk("R1 res_paddr", 32'(res_paddr), 32'(m_pa));
      end
    end
  end

  // memory responder with rotating latency 1..5
  int dly = 1, cnt = 0;
  logic [27:0] lat_a;
  always @(negedge clk) begin
    if (rst) begin cnt = 0; mem_resp_valid = 0; end
    else begin
      mem_resp_valid = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin mem_resp_valid = 1; mem_resp_data = rd(lat_a); end
      end
      if (mem_req_valid) begin lat_a = mem_req_addr; cnt = dly; dly = dly % 5 + 1; end
    end
  end

  task automatic walk(string tag, logic [31:0] va, logic [1:0] k, logic u, int hold, bit noisy);
    logic [1:0] ef; logic [27:0] ep;
    ref_walk(va, k, u, root_base, ef, ep);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_kind = k; req_user = u;
    @(negedge clk);
    if (noisy) begin req_vaddr = ~va; req_kind = 2'd0; req_user = 0; end
    else req_valid = 0;
    while (!res_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    chk({tag, " fault"}, 32'(res_fault), 32'(ef));
    chk({tag, " paddr"}, 32'(res_paddr), 32'(ep));
    res_ready = 1; req_valid = 0;
    @(negedge clk);
    res_ready = 0;
  endtask

  initial begin
    rst = 1; req_valid = 0; req_vaddr = 0; req_kind = 0; req_user = 0; res_ready = 0;
    mem_resp_data = 0; root_base = 28'h0010000;
    mem[32'h0010004] = {16'h0020, 16'h0001};
    mem[32'h0010FFC] = {16'h0ABC, 16'h0001};
    mem[32'h0020014] = {16'h1234, 16'h000D};
    mem[32'h002001C] = {16'h5555, 16'h001F};
    mem[32'h0ABCFFC] = {16'hFFFF, 16'h0015};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset req_ready", 32'(req_ready), 32'd1);
    chk("R11 reset mem_req_valid", 32'(mem_req_valid), 32'd0);
    chk("R11 reset res_valid", 32'(res_valid), 32'd0);
    live = 1;

    walk("R1 user read", 32'h00405123, 2'd0, 1, 0, 0);
    walk("R1 user write", 32'h00405FFF, 2'd1, 1, 2, 0);
    walk("R7 exec on no-exec page", 32'h00405000, 2'd2, 1, 0, 0);
    walk("R4 level-1 invalid", 32'h00800000, 2'd0, 0, 0, 0);
    walk("R5 level-2 invalid", 32'h00406010, 2'd0, 0, 1, 0);
    walk("R6 user on SUP page", 32'h00407ABC, 2'd0, 1, 0, 0);
    walk("R8 supervisor on SUP page", 32'h00407ABC, 2'd1, 0, 0, 0);
    walk("R3 top corner exec", 32'hFFFFFFFF, 2'd2, 1, 0, 0);
    walk("R7 write on read-exec page", 32'hFFFFF001, 2'd1, 0, 0, 0);
    walk("R7 kind 11", 32'h00405123, 2'd3, 0, 0, 0);
    walk("R9 busy requests ignored", 32'h00405ABC, 2'd0, 1, 4, 1);
    root_base = 28'h0020000 - 28'h0000004;
    walk("R2 other base", 32'h00400000, 2'd0, 0, 0, 0);
    root_base = 28'h0010000;

    @(negedge clk);
    req_valid = 1; req_vaddr = 32'h00405123; req_kind = 0; req_user = 1;
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
    rst = 1; live = 0;
    @(negedge clk); rst = 0;
    #1;
    chk("R11 mid-walk reset req_ready", 32'(req_ready), 32'd1);
    chk("R11 mid-walk reset mem_req_valid", 32'(mem_req_valid), 32'd0);
    chk("R11 mid-walk reset res_valid", 32'(res_valid), 32'd0);
    live = 1;
    walk("R1 after reset", 32'h00405123, 2'd0, 1, 0, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule